// File: doc/BRIEF.md
# Regulator Fault Supervisor with Power-Good

This block is the digital protection supervisor for a switching regulator. It runs on the system clock. A per-switching-cycle enable strobe marks the cycles on which comparator flags are counted. It takes single-bit flags from analog comparators: under-voltage, over-voltage, current-limit trip, over-temperature, high-side short, and two feedback-level flags used for output discharge. It also takes a soft-start-complete flag, a flag that reports the feedback is inside the power-good window, and the regulator enable.

Each fault has its own qualification:
- Over-voltage, current limit and under-voltage need consecutive-cycle counts.
- Under-voltage is masked until soft-start completes.
- Over-temperature and high-side short trip on the clock edge where they are seen.

Any qualified fault sets a sticky latch. The latch removes the PWM enable, records the first cause and starts a low-side discharge with hysteresis. The latch is released only by dropping enable or by reset.

Top module: `reg_fault_supervisor`

## Requirements
- R1: With `ss_done` high, `uv_flag` present on 16 (UV_CYCLES) consecutive strobe cycles sets the latch at the clock edge of the 16th strobe, with `fault_cause` = 1.
- R2: While `ss_done` is low, `uv_flag` never sets the latch, and its count is held at zero.
- R3: `ov_flag` present on 2 (OV_CYCLES) consecutive strobe cycles sets the latch with `fault_cause` = 2, whatever the state of `ss_done`.
- R4: `ilim_flag` present on 16 (OC_CYCLES) consecutive strobe cycles sets the latch with `fault_cause` = 3, whatever the state of `ss_done`.
- R5: A strobe cycle with a flag absent restarts that flag's count from zero. Clock cycles without the strobe neither advance nor clear a count, except that the under-voltage count is cleared whenever `ss_done` is low.
- R6: `hs_short_flag` seen at any clock edge, strobe or not, sets the latch at that edge with `fault_cause` = 5.
- R7: `otemp_flag` seen at any clock edge sets the latch at that edge with `fault_cause` = 4.
- R8: When several faults qualify at the same edge, the priority is short (5), then over-temperature (4), then over-voltage (2), then current limit (3), then under-voltage (1). While latched, `fault_cause` keeps the first value and never reads 0.
- R9: `discharge_on` turns on at the edge where the latch sets. While latched, it turns off at an edge where `fb_low_flag` is high and turns on again only at an edge where `fb_high_flag` is high. It is low whenever the latch is clear.
- R10: `power_good` is high only while `enable`, `ss_done` and `fb_in_window` are high and the latch is clear.
- R11: `pwm_en` equals `enable` while the latch is clear and is low while latched. A clock edge with `enable` low clears the latch, the cause and the counts. Fault flags have no effect while `enable` is low.
- R12: A synchronous `rst` clears the latch, the cause, the counts and `discharge_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycle_en | input | 1 | One-clock strobe per switching cycle |
| enable | input | 1 | Regulator enable |
| ss_done | input | 1 | Soft-start has reached the fault-enable point |
| uv_flag | input | 1 | Feedback below under-voltage level |
| ov_flag | input | 1 | Feedback above over-voltage level |
| ilim_flag | input | 1 | Pulse-by-pulse current-limit trip |
| otemp_flag | input | 1 | Die over-temperature |
| hs_short_flag | input | 1 | High-side short detected |
| fb_low_flag | input | 1 | Feedback below discharge-off level |
| fb_high_flag | input | 1 | Feedback above discharge-on level |
| fb_in_window | input | 1 | Feedback inside power-good window |
| pwm_en | output | 1 | Permission for the modulator to switch |
| fault_latched | output | 1 | Sticky fault latch |
| discharge_on | output | 1 | Low-side discharge request |
| power_good | output | 1 | Power-good indication |
| fault_cause | output | 3 | First fault: 0 none, 1 UV, 2 OV, 3 current limit, 4 over-temperature, 5 short |

## Verification
A count that advances on a non-strobe clock, or fails to restart, moves the edge at which `fault_latched` rises. The bench catches this in the exact clock where the latch differs from the reference. A wrong priority or a cause register that is overwritten shows at `fault_cause` one clock after the edge where the latch sets, or on any later clock while latched. A broken discharge hysteresis shows at `discharge_on` one clock after the feedback-level flag that should, or should not, have toggled it.

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor #(
  parameter int UV_CYCLES = 16,
  parameter int OV_CYCLES = 2,
  parameter int OC_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cycle_en,
  input  logic       enable,
  input  logic       ss_done,
  input  logic       uv_flag,
  input  logic       ov_flag,
  input  logic       ilim_flag,
  input  logic       otemp_flag,
  input  logic       hs_short_flag,
  input  logic       fb_low_flag,
  input  logic       fb_high_flag,
  input  logic       fb_in_window,
  output logic       pwm_en,
  output logic       fault_latched,
  output logic       discharge_on,
  output logic       power_good,
  output logic [2:0] fault_cause
);

  localparam int MAX_LIM = (UV_CYCLES > OC_CYCLES) ?
                           ((UV_CYCLES > OV_CYCLES) ? UV_CYCLES : OV_CYCLES) :
                           ((OC_CYCLES > OV_CYCLES) ? OC_CYCLES : OV_CYCLES);
  localparam int CNT_W = $clog2(MAX_LIM + 1);
  localparam logic [CNT_W-1:0] UV_LIM = CNT_W'(UV_CYCLES);
  localparam logic [CNT_W-1:0] OV_LIM = CNT_W'(OV_CYCLES);
  localparam logic [CNT_W-1:0] OC_LIM = CNT_W'(OC_CYCLES);

  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_UV    = 3'd1;
  localparam logic [2:0] C_OV    = 3'd2;
  localparam logic [2:0] C_OC    = 3'd3;
  localparam logic [2:0] C_OT    = 3'd4;
  localparam logic [2:0] C_SHORT = 3'd5;

  logic [CNT_W-1:0] uv_cnt, ov_cnt, oc_cnt;
  logic [CNT_W-1:0] uv_nxt, ov_nxt, oc_nxt;
  logic             fault_q, dis_q;
  logic [2:0]       cause_q, cause_sel;
  logic             uv_trip, ov_trip, oc_trip, any_trip, armed;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] lim);
    return (c >= lim) ? lim : c + CNT_W'(1);
  endfunction

  assign armed = enable & ~fault_q;

  always_comb begin
    uv_nxt = uv_cnt;
    ov_nxt = ov_cnt;
    oc_nxt = oc_cnt;
    if (cycle_en) begin
      uv_nxt = (uv_flag & ss_done) ? bump(uv_cnt, UV_LIM) : '0;
      ov_nxt = ov_flag   ? bump(ov_cnt, OV_LIM) : '0;
      oc_nxt = ilim_flag ? bump(oc_cnt, OC_LIM) : '0;
    end else if (!ss_done) begin
      uv_nxt = '0;
    end
  end

  assign uv_trip  = cycle_en & (uv_nxt == UV_LIM);
  assign ov_trip  = cycle_en & (ov_nxt == OV_LIM);
  assign oc_trip  = cycle_en & (oc_nxt == OC_LIM);
  assign any_trip = hs_short_flag | otemp_flag | ov_trip | oc_trip | uv_trip;

  always_comb begin
    if (hs_short_flag)   cause_sel = C_SHORT;
    else if (otemp_flag) cause_sel = C_OT;
    else if (ov_trip)    cause_sel = C_OV;
    else if (oc_trip)    cause_sel = C_OC;
    else if (uv_trip)    cause_sel = C_UV;
    else                 cause_sel = C_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst || !armed || any_trip) begin
      uv_cnt <= '0;
      ov_cnt <= '0;
      oc_cnt <= '0;
    end else begin
      uv_cnt <= uv_nxt;
      ov_cnt <= ov_nxt;
      oc_cnt <= oc_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      fault_q <= 1'b0;
      cause_q <= C_NONE;
    end else if (!fault_q && any_trip) begin
      fault_q <= 1'b1;
      cause_q <= cause_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable)              dis_q <= 1'b0;
    else if (!fault_q)               dis_q <= any_trip;
    else if (dis_q && fb_low_flag)   dis_q <= 1'b0;
    else if (!dis_q && fb_high_flag) dis_q <= 1'b1;
  end

  assign pwm_en        = enable & ~fault_q;
  assign fault_latched = fault_q;
  assign discharge_on  = dis_q;
  assign fault_cause   = cause_q;
  assign power_good    = enable & ss_done & fb_in_window & ~fault_q;

endmodule

// File: rtl/reg_fault_supervisor_chk.sv
module reg_fault_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       ss_done,
  input logic       hs_short_flag,
  input logic       otemp_flag,
  input logic       fb_low_flag,
  input logic       fb_in_window,
  input logic       pwm_en,
  input logic       fault_latched,
  input logic       discharge_on,
  input logic       power_good,
  input logic [2:0] fault_cause
);

  assert_short_latches_R6: assert property (@(posedge clk) disable iff (rst)
    (enable && !fault_latched && hs_short_flag) |=> (fault_latched && fault_cause == 3'd5));

  assert_otemp_latches_R7: assert property (@(posedge clk) disable iff (rst)
    (enable && !fault_latched && !hs_short_flag && otemp_flag) |=> (fault_latched && fault_cause == 3'd4));

  assert_cause_held_R8: assert property (@(posedge clk) disable iff (rst)
    (fault_latched && enable) |=> (fault_cause == $past(fault_cause)));

  assert_cause_valid_R8: assert property (@(posedge clk) disable iff (rst)
    fault_latched |-> (fault_cause != 3'd0));

  assert_discharge_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !fault_latched |-> !discharge_on);

  assert_discharge_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (fault_latched && discharge_on && !fb_low_flag && enable) |=> discharge_on);

  assert_pg_gate_R10: assert property (@(posedge clk) disable iff (rst)
    power_good |-> (ss_done && fb_in_window && !fault_latched));

  assert_pwm_off_R11: assert property (@(posedge clk) disable iff (rst)
    fault_latched |-> !pwm_en);

  assert_enable_clears_R11: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!fault_latched && fault_cause == 3'd0));

  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> (!fault_latched && !discharge_on && fault_cause == 3'd0));

endmodule

bind reg_fault_supervisor reg_fault_supervisor_chk chk_i (.*);

// File: tb/reg_fault_supervisor_tb_top.sv
module reg_fault_supervisor_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cycle_en = 1'b0, enable = 1'b0, ss_done = 1'b0;
  logic uv_flag = 1'b0, ov_flag = 1'b0, ilim_flag = 1'b0, otemp_flag = 1'b0;
  logic hs_short_flag = 1'b0, fb_low_flag = 1'b0, fb_high_flag = 1'b0, fb_in_window = 1'b0;
  logic pwm_en, fault_latched, discharge_on, power_good;
  logic [2:0] fault_cause;

  int checks = 0, failures = 0, cycles = 0;
  bit ce_gap = 1'b0;
  int ce_phase = 0;
  string cur_req = "R12";

  int m_uv = 0, m_ov = 0, m_oc = 0, m_cause = 0;
  bit m_fault = 0, m_dis = 0;

  always #2 clk = ~clk;

  reg_fault_supervisor dut_i (
    .clk(clk), .rst(rst), .cycle_en(cycle_en), .enable(enable), .ss_done(ss_done),
    .uv_flag(uv_flag), .ov_flag(ov_flag), .ilim_flag(ilim_flag), .otemp_flag(otemp_flag),
    .hs_short_flag(hs_short_flag), .fb_low_flag(fb_low_flag), .fb_high_flag(fb_high_flag),
    .fb_in_window(fb_in_window), .pwm_en(pwm_en), .fault_latched(fault_latched),
    .discharge_on(discharge_on), .power_good(power_good), .fault_cause(fault_cause));

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      report();
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int code;
    if (rst || !enable) begin
      m_fault = 0; m_cause = 0; m_dis = 0; m_uv = 0; m_ov = 0; m_oc = 0;
    end else if (m_fault) begin
      if (m_dis && fb_low_flag) m_dis = 0;
      else if (!m_dis && fb_high_flag) m_dis = 1;
    end else begin
      if (cycle_en) begin
        m_uv = (uv_flag && ss_done) ? m_uv + 1 : 0;
        m_ov = ov_flag ? m_ov + 1 : 0;
        m_oc = ilim_flag ? m_oc + 1 : 0;
      end else if (!ss_done) m_uv = 0;
      code = 0;
      if (hs_short_flag) code = 5;
      else if (otemp_flag) code = 4;
      else if (cycle_en && m_ov >= 2) code = 2;
      else if (cycle_en && m_oc >= 16) code = 3;
      else if (cycle_en && m_uv >= 16) code = 1;
      if (code != 0) begin
        m_fault = 1; m_cause = code; m_dis = 1; m_uv = 0; m_ov = 0; m_oc = 0;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(cur_req, "fault_latched", fault_latched, m_fault);
    check(cur_req, "fault_cause", fault_cause, m_cause);
    check(cur_req, "discharge_on", discharge_on, m_dis);
    check(cur_req, "pwm_en", pwm_en, enable && !m_fault);
    check(cur_req, "power_good", power_good, enable && ss_done && fb_in_window && !m_fault);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) begin
      if (ce_gap) begin
        cycle_en = (ce_phase % 2 == 0);
        ce_phase++;
      end else cycle_en = 1'b1;
      tick();
    end
    cycle_en = 1'b0;
  endtask

  task automatic clear_all();
    enable = 1'b0;
    {uv_flag, ov_flag, ilim_flag, otemp_flag, hs_short_flag, fb_low_flag, fb_high_flag} = '0;
    tick();
    enable = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R12";
    tick(); tick();
    check("R12", "fault_latched after reset", fault_latched, 0);
    check("R12", "cause after reset", fault_cause, 0);
    rst = 1'b0;
    enable = 1'b1;

    cur_req = "R2";
    uv_flag = 1'b1;
    steps(40);
    check("R2", "uv masked during soft-start", fault_latched, 0);

    cur_req = "R5";
    ss_done = 1'b1;
    steps(15);
    uv_flag = 1'b0; steps(1); uv_flag = 1'b1;
    steps(15);
    check("R5", "uv count restarted", fault_latched, 0);
    uv_flag = 1'b0; steps(1); uv_flag = 1'b1;

    cur_req = "R1";
    steps(15);
    check("R1", "uv before 16th", fault_latched, 0);
    steps(1);
    check("R1", "uv at 16th", fault_latched, 1);
    check("R1", "uv cause", fault_cause, 1);
    uv_flag = 1'b0;

    cur_req = "R9";
    check("R9", "discharge on at latch", discharge_on, 1);
    tick();
    fb_low_flag = 1'b1; tick(); fb_low_flag = 1'b0;
    check("R9", "discharge off at low", discharge_on, 0);
    tick(); tick();
    check("R9", "discharge stays off", discharge_on, 0);
    fb_high_flag = 1'b1; tick(); fb_high_flag = 1'b0;
    check("R9", "discharge back on at high", discharge_on, 1);

    cur_req = "R11";
    enable = 1'b0;
    ov_flag = 1'b1; hs_short_flag = 1'b1; otemp_flag = 1'b1;
    steps(6);
    check("R11", "faults ignored while disabled", fault_latched, 0);
    check("R11", "pwm off when disabled", pwm_en, 0);
    {ov_flag, hs_short_flag, otemp_flag} = '0;
    enable = 1'b1; tick();
    check("R11", "pwm on after clear", pwm_en, 1);

    cur_req = "R3";
    ss_done = 1'b0;
    ce_gap = 1'b1; ce_phase = 0;
    ov_flag = 1'b1;
    steps(2);
    check("R3", "ov after one strobe", fault_latched, 0);
    steps(1);
    check("R3", "ov after two strobes", fault_latched, 1);
    check("R3", "ov cause", fault_cause, 2);
    ov_flag = 1'b0;
    clear_all();

    cur_req = "R4";
    ce_gap = 1'b0;
    ilim_flag = 1'b1;
    steps(15);
    check("R4", "ilim before 16th", fault_latched, 0);
    steps(1);
    check("R4", "ilim cause", fault_cause, 3);
    ilim_flag = 1'b0;
    clear_all();

    cur_req = "R6";
    hs_short_flag = 1'b1; tick(); hs_short_flag = 1'b0;
    check("R6", "short latched without strobe", fault_latched, 1);
    check("R6", "short cause", fault_cause, 5);
    clear_all();

    cur_req = "R7";
    otemp_flag = 1'b1; tick(); otemp_flag = 1'b0;
    check("R7", "otemp cause", fault_cause, 4);
    clear_all();

    cur_req = "R8";
    ov_flag = 1'b1; ilim_flag = 1'b1;
    steps(1);
    otemp_flag = 1'b1;
    steps(1);
    check("R8", "otemp beats ov", fault_cause, 4);
    hs_short_flag = 1'b1;
    steps(3);
    check("R8", "first cause held", fault_cause, 4);
    {ov_flag, ilim_flag, otemp_flag, hs_short_flag} = '0;
    clear_all();

    cur_req = "R10";
    ss_done = 1'b0; fb_in_window = 1'b1; tick();
    check("R10", "pg low before fault-enable", power_good, 0);
    ss_done = 1'b1; tick();
    check("R10", "pg high in window", power_good, 1);
    fb_in_window = 1'b0; tick();
    check("R10", "pg low out of window", power_good, 0);
    fb_in_window = 1'b1;

    cur_req = "R12";
    hs_short_flag = 1'b1; tick(); hs_short_flag = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0;
    check("R12", "reset clears latch", fault_latched, 0);
    check("R12", "reset clears discharge", discharge_on, 0);
    tick();

    report();
  end

endmodule